// File: doc/BRIEF.md
# Saturating Fixed-Point LMS Noise Canceller

This block is an integer transversal adaptive filter meant for noise cancelling. A primary input carries a noise sample correlated with the disturbance. A reference input carries the wanted signal with that disturbance added. On every accepted sample the primary value is pushed into a tap delay line. A convolution stage multiplies each tap by its weight, quantizes each product back to working precision and sums the results into a wide accumulator. The filter output is the accumulator clamped to the sample range. The error, reference minus filter output, is the cleaned signal. An adaptation stage then moves every weight along the error, with a second, separate quantization point on the update product.

Samples and weights are signed fixed point with one integer bit, so a weight of 0x7FFF is just below unity. The step size is a power of two and is applied as an arithmetic right shift. A mode input picks between the standard error-times-tap update and a sign-error update, which uses only the sign of the error and so keeps adapting when small errors would otherwise quantize to zero. Any result that overflows is clamped to the extreme value of its sign. The whole sample is processed in a single clock: outputs and updated weights appear on the cycle after the strobe, and the next sample can be accepted on that cycle.

Top module: `lms_noise_canceller`

## Requirements
- R1: When `valid_i` is high, `prim_i` enters tap 0 and every other tap takes the value of the tap below it. The filter output is the sum over taps of quant(tap × weight, 15), computed with the new tap contents and the weights held before this sample.
- R2: quant(v, s) is an arithmetic right shift of v by s. When `round_i` is 0 this shift truncates. When `round_i` is 1, 2^(s-1) is added to v before the shift (round half up). When s is 0, v passes through unchanged. `round_i` applies at both quantization points.
- R3: The filter output and the error are clamped to +32767 when their exact value is larger and to -32768 when it is smaller.
- R4: The error is clamp(ref − y), where ref is `ref_i` of the same sample and y is the clamped filter output.
- R5: With `sign_mode_i` = 0, each weight becomes clamp(w + quant(e × tap, 15 + `mu_shift_i`)), using the new tap contents.
- R6: With `sign_mode_i` = 1, each weight becomes clamp(w + quant(s, `mu_shift_i`)), where s is the tap when e > 0, minus the tap when e < 0, and 0 when e = 0. A zero error leaves every weight unchanged.
- R7: A weight update that overflows is clamped to +32767 or -32768 according to the sign of the exact result.
- R8: While `rst_ni` is low, the taps, the weights, `y_o`, `err_o` and `out_valid_o` are all zero.
- R9: `out_valid_o` is high on exactly the cycle after each cycle in which `valid_i` is high. Cycles with `valid_i` low change neither the taps nor the weights, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| prim_i | input | 16 | Primary (noise) sample, signed |
| ref_i | input | 16 | Reference (signal plus noise) sample, signed |
| sign_mode_i | input | 1 | 1 selects the sign-error update |
| round_i | input | 1 | 1 selects round half up, 0 selects truncation |
| mu_shift_i | input | 4 | Step size as a right-shift count |
| out_valid_o | output | 1 | Outputs and weights updated for the last sample |
| y_o | output | 16 | Filter output, signed |
| err_o | output | 16 | Error (cleaned signal), signed |
| w_o | output | 128 | Weights; weight k is in bits [16k+15:16k] |

## Verification
The hardest states to reach from the ports are the clamped weights and the clamped outputs. A random signal leaves the weights small, so these states almost never occur. The stimulus therefore uses the sign-error mode with a zero step shift and a constant large primary input. This drives the first weight into its clamp on the second sample and the filter output into its clamp on the third. A reference of -32768 then forces the error clamp as well. A mid-run reset followed by a zero reference produces an exact zero error, which exercises the no-change rule of the sign-error update.

// File: rtl/lms_pkg.sv
package lms_pkg;

  // arithmetic shift right with optional round-half-up
  function automatic logic signed [63:0] q_shift(input logic signed [63:0] v,
                                                 input logic [5:0] sh,
                                                 input logic rnd);
    logic signed [63:0] b;
    b = v;
    if (rnd && sh != 6'd0) b = v + (64'sd1 <<< (sh - 6'd1));
    return b >>> sh;
  endfunction

  // clamp to a signed range of the given width
  function automatic logic signed [63:0] clip(input logic signed [63:0] v,
                                              input int width);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (width - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/lms_tap_line.sv
module lms_tap_line #(
  parameter int DW    = 16,
  parameter int NTAPS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] din_i,
  output logic signed [DW-1:0] taps_o [NTAPS]
);

  logic signed [DW-1:0] x_q [NTAPS];

  // taps_o is the post-shift view used by the same-cycle math
  always_comb begin
    taps_o[0] = shift_i ? din_i : x_q[0];
    for (int k = 1; k < NTAPS; k++)
      taps_o[k] = shift_i ? x_q[k-1] : x_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAPS; k++) x_q[k] <= '0;
    end else begin
      for (int k = 0; k < NTAPS; k++) x_q[k] <= taps_o[k];
    end
  end

endmodule

// File: rtl/lms_tap_cell.sv
module lms_tap_cell
  import lms_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int FB    = 15,
  parameter int MUW   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [DW-1:0]    x_i,
  input  logic signed [DW-1:0]    err_i,
  input  logic                    sign_mode_i,
  input  logic                    round_i,
  input  logic [MUW-1:0]          mu_i,
  output logic signed [DW-1:0]    w_o,
  output logic signed [ACC_W-1:0] prod_q_o
);

  logic signed [DW-1:0] w_q;
  logic signed [63:0]   conv_full;
  logic signed [63:0]   upd_src;
  logic [5:0]           upd_sh;
  logic signed [63:0]   delta;
  logic signed [63:0]   w_sum;

  assign w_o = w_q;

  // convolution-stage quantization point
  always_comb begin
    conv_full = 64'(x_i) * 64'(w_q);
    prod_q_o  = ACC_W'(q_shift(conv_full, 6'(FB), round_i));
  end

  // adaptation-stage quantization point
  always_comb begin
    if (sign_mode_i) begin
      if (err_i > 0)      upd_src = 64'(x_i);
      else if (err_i < 0) upd_src = -64'(x_i);
      else                upd_src = 64'sd0;
      upd_sh = 6'(mu_i);
    end else begin
      upd_src = 64'(err_i) * 64'(x_i);
      upd_sh  = 6'(FB) + 6'(mu_i);
    end
    delta = q_shift(upd_src, upd_sh, round_i);
    w_sum = clip(64'(w_q) + delta, DW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    w_q <= '0;
    else if (upd_i) w_q <= DW'(w_sum);
  end

endmodule

// File: rtl/lms_err_unit.sv
module lms_err_unit
  import lms_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int NTAPS = 8
) (
  input  logic signed [ACC_W-1:0] prod_q_i [NTAPS],
  input  logic signed [DW-1:0]    ref_i,
  output logic signed [DW-1:0]    y_o,
  output logic signed [DW-1:0]    err_o
);

  logic signed [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) acc = acc + prod_q_i[k];
    y_o   = DW'(clip(64'(acc), DW));
    err_o = DW'(clip(64'(ref_i) - 64'(y_o), DW));
  end

endmodule

// File: rtl/lms_noise_canceller.sv
module lms_noise_canceller #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int NTAPS = 8,
  parameter int MUW   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic signed [DW-1:0]  prim_i,
  input  logic signed [DW-1:0]  ref_i,
  input  logic                  sign_mode_i,
  input  logic                  round_i,
  input  logic [MUW-1:0]        mu_shift_i,
  output logic                  out_valid_o,
  output logic signed [DW-1:0]  y_o,
  output logic signed [DW-1:0]  err_o,
  output logic [NTAPS*DW-1:0]   w_o
);

  localparam int FB = DW - 1;

  logic signed [DW-1:0]    x_nx   [NTAPS];
  logic signed [ACC_W-1:0] prod_q [NTAPS];
  logic signed [DW-1:0]    y_c;
  logic signed [DW-1:0]    err_c;

  lms_tap_line #(.DW(DW), .NTAPS(NTAPS)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_i),
    .din_i   (prim_i),
    .taps_o  (x_nx)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    lms_tap_cell #(.DW(DW), .ACC_W(ACC_W), .FB(FB), .MUW(MUW)) u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .upd_i       (valid_i),
      .x_i         (x_nx[k]),
      .err_i       (err_c),
      .sign_mode_i (sign_mode_i),
      .round_i     (round_i),
      .mu_i        (mu_shift_i),
      .w_o         (w_o[k*DW +: DW]),
      .prod_q_o    (prod_q[k])
    );
  end

  lms_err_unit #(.DW(DW), .ACC_W(ACC_W), .NTAPS(NTAPS)) u_err (
    .prod_q_i (prod_q),
    .ref_i    (ref_i),
    .y_o      (y_c),
    .err_o    (err_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      y_o         <= '0;
      err_o       <= '0;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        y_o   <= y_c;
        err_o <= err_c;
      end
    end
  end

endmodule

// File: rtl/lms_chk.sv
module lms_chk #(
  parameter int DW    = 16,
  parameter int NTAPS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic signed [DW-1:0] ref_i,
  input logic                 sign_mode_i,
  input logic                 out_valid_o,
  input logic signed [DW-1:0] y_o,
  input logic signed [DW-1:0] err_o,
  input logic [NTAPS*DW-1:0]  w_o
);

  logic signed [DW-1:0] ref_q;
  logic signed [DW:0]   diff;
  logic signed [DW-1:0] err_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= ref_i;
  end

  always_comb begin
    diff = {ref_q[DW-1], ref_q} - {y_o[DW-1], y_o};
    if (diff > $signed({2'b00, {(DW-1){1'b1}}}))       err_exp = {1'b0, {(DW-1){1'b1}}};
    else if (diff < $signed({2'b11, {(DW-1){1'b0}}}))  err_exp = {1'b1, {(DW-1){1'b0}}};
    else                                               err_exp = diff[DW-1:0];
  end

  always @(posedge clk_i) begin
    if (!rst_ni)
      assert_reset_zero_R8: assert (w_o == '0 && y_o == '0 && err_o == '0 && !out_valid_o);
  end

  assert_valid_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> out_valid_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!out_valid_o && $stable(w_o)));

  assert_err_diff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (err_o == err_exp));

  assert_sign_zero_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(sign_mode_i) && err_o == '0) |-> (w_o == $past(w_o)));

endmodule

bind lms_noise_canceller lms_chk #(.DW(DW), .NTAPS(NTAPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ref_i       (ref_i),
  .sign_mode_i (sign_mode_i),
  .out_valid_o (out_valid_o),
  .y_o         (y_o),
  .err_o       (err_o),
  .w_o         (w_o)
);

// File: tb/sim_lms_noise_canceller.sv
module sim_lms_noise_canceller;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NT = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic valid_i = 1'b0;
  logic signed [DW-1:0] prim_i = '0;
  logic signed [DW-1:0] ref_i = '0;
  logic sign_mode_i = 1'b0;
  logic round_i = 1'b0;
  logic [3:0] mu_shift_i = '0;
  logic out_valid_o;
  logic signed [DW-1:0] y_o;
  logic signed [DW-1:0] err_o;
  logic [NT*DW-1:0] w_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic signed [DW-1:0] y;
    logic signed [DW-1:0] e;
    logic [NT*DW-1:0]     w;
    string                tag;
  } exp_t;
  exp_t exp_q[$];

  logic signed [DW-1:0] mx [NT];
  logic signed [DW-1:0] mw [NT];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lms_noise_canceller u0 (.*);

  function automatic logic signed [63:0] m_qs(input logic signed [63:0] v, input int sh, input bit rnd);
    logic signed [63:0] t;
    t = v;
    if (rnd && sh > 0) t = t + (64'sd1 <<< (sh - 1));
    return t >>> sh;
  endfunction

  function automatic logic signed [63:0] m_clip(input logic signed [63:0] v);
    if (v > 64'sd32767) return 64'sd32767;
    if (v < -64'sd32768) return -64'sd32768;
    return v;
  endfunction

  function automatic logic [NT*DW-1:0] pack_w();
    logic [NT*DW-1:0] r;
    for (int k = 0; k < NT; k++) r[k*DW +: DW] = mw[k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NT; k++) begin mx[k] = '0; mw[k] = '0; end
  endtask

  task automatic send(input int p, input int r, input bit sm, input bit rnd, input int mu, input string tag);
    logic signed [63:0] acc, y, e, s, d;
    exp_t it;
    @(negedge clk_i);
    valid_i = 1'b1; prim_i = DW'(p); ref_i = DW'(r);
    sign_mode_i = sm; round_i = rnd; mu_shift_i = 4'(mu);
    for (int k = NT - 1; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = DW'(p);
    acc = 0;
    for (int k = 0; k < NT; k++) acc += m_qs(64'(mx[k]) * 64'(mw[k]), 15, rnd);
    y = m_clip(acc);
    e = m_clip(64'(r) - y);
    for (int k = 0; k < NT; k++) begin
      if (sm) begin
        s = (e > 0) ? 64'(mx[k]) : (e < 0) ? -64'(mx[k]) : 64'sd0;
        d = m_qs(s, mu, rnd);
      end else begin
        d = m_qs(e * 64'(mx[k]), 15 + mu, rnd);
      end
      mw[k] = DW'(m_clip(64'(mw[k]) + d));
    end
    it.y = DW'(y); it.e = DW'(e); it.w = pack_w(); it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      prim_i = DW'(i * 977 - 12000); ref_i = DW'(31000 - i * 555);
      sign_mode_i = i[0]; mu_shift_i = 4'(i);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk(w_o == '0, tag, "weights", longint'(w_o[15:0]), 0);
    chk(y_o == '0 && err_o == '0, tag, "y/err", longint'(y_o), 0);
    chk(!out_valid_o, tag, "out_valid", longint'(out_valid_o), 0);
  endtask

  // monitor: pops one expected item per output strobe
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9", "unexpected out_valid", 1, 0);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        chk(y_o == it.y, it.tag, "y_o", longint'(y_o), longint'(it.y));
        chk(err_o == it.e, it.tag, "err_o", longint'(err_o), longint'(it.e));
        for (int k = 0; k < NT; k++)
          chk(w_o[k*DW +: DW] == it.w[k*DW +: DW], it.tag, $sformatf("w[%0d]", k),
              longint'($signed(w_o[k*DW +: DW])), longint'($signed(it.w[k*DW +: DW])));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lcg;
    model_clear();
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_reset_state("R8");
    rst_ni = 1'b1;

    // R4/R5: zero weights give y=0 and err=ref
    send(1000, 2000, 0, 0, 4, "R4");
    send(-3000, 500, 0, 0, 4, "R5");
    send(12000, -7000, 0, 0, 2, "R5");
    send(-20000, 15000, 0, 0, 0, "R5");

    // R1/R2: pseudo-random stream, truncation then rounding
    lcg = 12345;
    for (int i = 0; i < 40; i++) begin
      int p, r;
      lcg = lcg * 1103515245 + 12345;
      p = (lcg >>> 8) % 20000;
      lcg = lcg * 1103515245 + 12345;
      r = p / 2 + (lcg >>> 9) % 6000;
      send(p, r, 0, i >= 20, 1 + (i % 5), (i >= 20) ? "R2" : "R1");
    end

    // R6: sign-error mode on random data
    for (int i = 0; i < 20; i++) begin
      lcg = lcg * 1103515245 + 12345;
      send((lcg >>> 7) % 25000, (i * 3111) % 30000 - 15000, 1, i[0], 3 + (i % 4), "R6");
    end

    // R9: idle cycles must leave taps and weights alone
    idle(5);
    @(negedge clk_i);
    chk(!out_valid_o, "R9", "out_valid while idle", longint'(out_valid_o), 0);
    chk(w_o == pack_w(), "R9", "weights while idle", longint'($signed(w_o[15:0])), longint'(mw[0]));
    send(4000, 100, 0, 1, 3, "R9");

    // R8: reset mid run
    idle(2);
    rst_ni = 1'b0;
    model_clear();
    @(negedge clk_i);
    check_reset_state("R8");
    rst_ni = 1'b1;

    // R6: zero error in sign mode keeps weights
    send(1000, 0, 1, 0, 0, "R6");
    send(-2500, 0, 1, 1, 2, "R6");

    // R7/R3: drive weights and outputs into their clamps
    send(30000, 32767, 1, 0, 0, "R7");
    send(30000, 32767, 1, 0, 0, "R7");
    send(30000, 32767, 1, 0, 0, "R3");
    send(30000, -32768, 1, 0, 0, "R3");
    send(-30000, 32767, 0, 1, 0, "R7");
    send(-30000, 32767, 0, 0, 0, "R3");

    idle(3);
    chk(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule